// File: doc/BRIEF.md
# Ring access switch controller

This block is the digital control for the four solid-state switches that connect a telephone line either to the voice circuit or to a ringing generator. It drives two line-break enables (tip and ring side) and two ringing enables (ring-return and ring-access). Selection comes from a mode input, a level-sensitive state-hold input and an active-low external shutdown input. The block also watches a sampled die temperature code and a signed battery voltage code. Each has a hysteretic fault monitor that turns every switch off. The thermal fault is also reported on an active-low status output.

The sequencer keeps the two switch groups from overlapping in the harmful direction. On the way into ringing, all enables stay off for a programmable gap before the ringing pair closes. On the way out of ringing, the ring-return enable opens at once and the line-break pair closes at once. The ring-access enable stays on, because the real device is a thyristor that releases only at a current zero crossing. It drops on the first zero-crossing strobe, or after a programmable cycle count if no strobe arrives.

Temperature and battery samples are plain streams with a valid qualifier and no back-pressure. A sample is taken on every clock edge where its valid input is high and is otherwise ignored. The external shutdown input should be tied high when unused. It is resynchronised through a two-flop chain.

Top module: `ring_switch_ctrl`

## Requirements
- R1: With the hold input low and no fault, mode 0 gives tip and ring line-break enables on and ring-return and ring-access enables off. As a vector {tip, ring, return, access} this is 1100.
- R2: With mode 1 held long enough to pass the gap, the vector is 0011: line-break enables off, ring-return and ring-access enables on.
- R3: While the hold input is high, mode changes have no effect. The switches keep the mode value sampled in the last cycle the hold input was low.
- R4: When the hold input returns low, the sequencer acts on the live mode input from the next clock edge.
- R5: The external shutdown input, active low, turns all four enables off two clock edges after it falls, whatever the hold and mode inputs are. This also applies to a ring-access enable waiting for a zero crossing. External shutdown leaves the status output high. After the input returns high, the switches re-enter the selected mode through the normal sequence.
- R6: A valid temperature code above 150 sets the thermal fault at the next edge, and the code value 150 itself does not trip it. The fault clears only on a valid code below 139, that is 138 or less. While the fault is set, all enables are off and the status output is low. Otherwise the status output is high.
- R7: A valid signed battery code (1 V per LSB) above −10 sets the battery fault at the next edge, and −10 itself does not trip it. The fault clears only on a valid code below −15. While it is set, all enables are off and the status output stays high.
- R8: On leaving ringing, the vector becomes 1101. Ring-access stays on until the edge after a zero-crossing strobe, and the vector then becomes 1100.
- R9: On entering ringing from idle, all enables are off for GAP_CYC cycles before the ringing pair turns on. The tip line-break enable and the ring-return enable are never on together.
- R10: If no zero-crossing strobe arrives, ring-access stays on for exactly TO_CYC cycles after leaving ringing and then turns off.
- R11: During and after reset, all enables are off and the status output is low. Both fault monitors start in fault, so the switches stay off until one valid in-range sample of each kind has cleared them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | Mode select: 0 idle/talk, 1 ringing |
| hold_i | input | 1 | State hold: 0 transparent, 1 keep captured mode |
| sd_ext_n_i | input | 1 | External shutdown, active low; tie high when unused |
| temp_valid_i | input | 1 | Temperature sample valid |
| temp_code_i | input | TEMP_W | Unsigned die temperature, 1 °C per LSB |
| vbat_valid_i | input | 1 | Battery sample valid |
| vbat_code_i | input | VBAT_W | Signed battery voltage, 1 V per LSB |
| zc_i | input | 1 | Ringing current zero-crossing strobe |
| lb_tip_en_o | output | 1 | Tip line-break switch enable |
| lb_ring_en_o | output | 1 | Ring line-break switch enable |
| rr_en_o | output | 1 | Ring-return switch enable |
| ra_en_o | output | 1 | Ring-access switch enable |
| sd_stat_n_o | output | 1 | Thermal status: low while the thermal fault is set |

## Verification
The hardest window to reach is the drain interval after ringing, where ring-access is still on beside closed line-break switches. Three things happen inside that window: a zero-crossing strobe, the timeout running out with no strobe, and an external shutdown pulled mid-window. The bench reaches it by driving mode 1 past the break-before-make gap and then dropping mode. It shortens the timeout through a parameter so the no-strobe case can be checked at its exact final cycle. The hysteresis thresholds are probed by walking the temperature and battery codes across both edges of each band, one sample at a time.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_IDLE,
    ST_GAP,
    ST_RING,
    ST_DRAIN
  } rsc_state_e;

  typedef struct packed {
    logic lb_tip;
    logic lb_ring;
    logic rr;
    logic ra;
  } rsc_sw_t;
endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rsc_hyst_mon.sv
// Hysteretic level monitor: trips above SET_TH, releases below CLR_TH.
module rsc_hyst_mon #(
  parameter int W      = 9,
  parameter int SET_TH = 150,
  parameter int CLR_TH = 139
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                valid,
  input  logic signed [W-1:0] sample,
  output logic                fault
);
  logic fault_q;
  logic over_set;
  logic under_clr;

  assign over_set  = (sample > SET_TH);
  assign under_clr = (sample < CLR_TH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b1;
    end else if (valid) begin
      if (fault_q && under_clr)      fault_q <= 1'b0;
      else if (!fault_q && over_set) fault_q <= 1'b1;
    end
  end

  assign fault = fault_q;
endmodule

// File: rtl/rsc_hold.sv
// Mode hold: transparent while hold is low, keeps the last sampled mode while high.
module rsc_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic mode,
  input  logic hold,
  output logic tgt
);
  logic held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     held_q <= 1'b0;
    else if (!hold) held_q <= mode;
  end

  assign tgt = hold ? held_q : mode;
endmodule

// File: rtl/rsc_seq.sv
module rsc_seq
  import rsc_pkg::*;
#(
  parameter int GAP_CYC = 2,
  parameter int TO_CYC  = 2500000
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tgt,
  input  logic    kill,
  input  logic    zc,
  output rsc_sw_t sw
);
  localparam int GW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam int TW = (TO_CYC > 1) ? $clog2(TO_CYC) : 1;
  localparam logic [GW-1:0] GAP_LD = GW'(GAP_CYC - 1);
  localparam logic [TW-1:0] TO_LD  = TW'(TO_CYC - 1);

  rsc_state_e    st_q, st_n;
  logic [GW-1:0] gap_q, gap_n;
  logic [TW-1:0] to_q, to_n;
  rsc_sw_t       dec;

  always_comb begin
    st_n  = st_q;
    gap_n = gap_q;
    to_n  = to_q;
    if (kill) begin
      st_n = ST_OFF;
    end else begin
      case (st_q)
        ST_OFF: begin
          if (tgt) begin
            st_n  = ST_GAP;
            gap_n = GAP_LD;
          end else begin
            st_n = ST_IDLE;
          end
        end
        ST_IDLE: begin
          if (tgt) begin
            st_n  = ST_GAP;
            gap_n = GAP_LD;
          end
        end
        ST_GAP: begin
          if (!tgt)             st_n = ST_IDLE;
          else if (gap_q == '0) st_n = ST_RING;
          else                  gap_n = gap_q - 1'b1;
        end
        ST_RING: begin
          if (!tgt) begin
            st_n = ST_DRAIN;
            to_n = TO_LD;
          end
        end
        ST_DRAIN: begin
          if (zc || to_q == '0) st_n = ST_IDLE;
          else                  to_n = to_q - 1'b1;
        end
        default: st_n = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_OFF;
      gap_q <= '0;
      to_q  <= '0;
    end else begin
      st_q  <= st_n;
      gap_q <= gap_n;
      to_q  <= to_n;
    end
  end

  always_comb begin
    dec = '0;
    case (st_q)
      ST_IDLE:  begin dec.lb_tip = 1'b1; dec.lb_ring = 1'b1; end
      ST_RING:  begin dec.rr = 1'b1; dec.ra = 1'b1; end
      ST_DRAIN: begin dec.lb_tip = 1'b1; dec.lb_ring = 1'b1; dec.ra = 1'b1; end
      default:  dec = '0;
    endcase
  end

  assign sw = kill ? '0 : dec;
endmodule

// File: rtl/ring_switch_ctrl.sv
module ring_switch_ctrl
  import rsc_pkg::*;
#(
  parameter int TEMP_W      = 8,
  parameter int VBAT_W      = 8,
  parameter int T_TRIP      = 150,
  parameter int T_CLEAR     = 139,
  parameter int V_TRIP      = -10,
  parameter int V_CLEAR     = -15,
  parameter int GAP_CYC     = 2,
  parameter int TO_CYC      = 2500000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic              hold_i,
  input  logic              sd_ext_n_i,
  input  logic              temp_valid_i,
  input  logic [TEMP_W-1:0] temp_code_i,
  input  logic              vbat_valid_i,
  input  logic [VBAT_W-1:0] vbat_code_i,
  input  logic              zc_i,
  output logic              lb_tip_en_o,
  output logic              lb_ring_en_o,
  output logic              rr_en_o,
  output logic              ra_en_o,
  output logic              sd_stat_n_o
);
  localparam int TS_W = TEMP_W + 1;

  logic    sd_ext_n_s;
  logic    therm_f;
  logic    vbat_f;
  logic    tgt;
  logic    kill;
  rsc_sw_t sw;

  logic signed [TS_W-1:0]   temp_s;
  logic signed [VBAT_W-1:0] vbat_s;

  assign temp_s = $signed({1'b0, temp_code_i});
  assign vbat_s = $signed(vbat_code_i);

  rsc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sd_sync (
    .clk(clk), .rst_n(rst_n), .d(sd_ext_n_i), .q(sd_ext_n_s)
  );

  rsc_hyst_mon #(.W(TS_W), .SET_TH(T_TRIP), .CLR_TH(T_CLEAR)) u_therm (
    .clk(clk), .rst_n(rst_n), .valid(temp_valid_i), .sample(temp_s), .fault(therm_f)
  );

  rsc_hyst_mon #(.W(VBAT_W), .SET_TH(V_TRIP), .CLR_TH(V_CLEAR)) u_vbat (
    .clk(clk), .rst_n(rst_n), .valid(vbat_valid_i), .sample(vbat_s), .fault(vbat_f)
  );

  rsc_hold u_hold (
    .clk(clk), .rst_n(rst_n), .mode(mode_i), .hold(hold_i), .tgt(tgt)
  );

  assign kill = !sd_ext_n_s || therm_f || vbat_f;

  rsc_seq #(.GAP_CYC(GAP_CYC), .TO_CYC(TO_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .tgt(tgt), .kill(kill), .zc(zc_i), .sw(sw)
  );

  assign lb_tip_en_o  = sw.lb_tip;
  assign lb_ring_en_o = sw.lb_ring;
  assign rr_en_o      = sw.rr;
  assign ra_en_o      = sw.ra;
  assign sd_stat_n_o  = !therm_f;
endmodule

// File: rtl/rsc_chk.sv
module rsc_chk #(
  parameter int TEMP_W = 8,
  parameter int VBAT_W = 8,
  parameter int T_TRIP = 150,
  parameter int V_TRIP = -10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              temp_valid_i,
  input logic [TEMP_W-1:0] temp_code_i,
  input logic              vbat_valid_i,
  input logic [VBAT_W-1:0] vbat_code_i,
  input logic              zc_i,
  input logic              lb_tip_en_o,
  input logic              lb_ring_en_o,
  input logic              rr_en_o,
  input logic              ra_en_o,
  input logic              sd_stat_n_o
);
  logic any_on;
  assign any_on = lb_tip_en_o || lb_ring_en_o || rr_en_o || ra_en_o;

  p_therm_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_stat_n_o |-> !any_on);

  p_therm_trip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_valid_i && ($signed({1'b0, temp_code_i}) > T_TRIP)) |=> !sd_stat_n_o);

  p_vbat_trip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vbat_valid_i && ($signed(vbat_code_i) > V_TRIP)) |=> !any_on);

  p_zc_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_en_o && lb_tip_en_o && zc_i) |=> !ra_en_o);

  p_bbm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rr_en_o) |-> $past(!lb_tip_en_o && !lb_ring_en_o));

  p_no_tip_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(lb_tip_en_o && rr_en_o));
endmodule

bind ring_switch_ctrl rsc_chk #(
  .TEMP_W(TEMP_W), .VBAT_W(VBAT_W), .T_TRIP(T_TRIP), .V_TRIP(V_TRIP)
) u_rsc_chk (
  .clk(clk), .rst_n(rst_n),
  .temp_valid_i(temp_valid_i), .temp_code_i(temp_code_i),
  .vbat_valid_i(vbat_valid_i), .vbat_code_i(vbat_code_i),
  .zc_i(zc_i),
  .lb_tip_en_o(lb_tip_en_o), .lb_ring_en_o(lb_ring_en_o),
  .rr_en_o(rr_en_o), .ra_en_o(ra_en_o), .sd_stat_n_o(sd_stat_n_o)
);

// File: tb/ring_switch_ctrl_bench.sv
`timescale 1ns/1ps
module ring_switch_ctrl_bench;
  localparam int TO_T  = 40;
  localparam int GAP_T = 2;

  localparam logic [3:0] V_OFF   = 4'b0000;
  localparam logic [3:0] V_IDLE  = 4'b1100;
  localparam logic [3:0] V_RING  = 4'b0011;
  localparam logic [3:0] V_DRAIN = 4'b1101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0, hold = 1'b0, sd_ext_n = 1'b1, zc = 1'b0;
  logic temp_valid = 1'b0, vbat_valid = 1'b0;
  logic [7:0] temp_code = 8'd0;
  logic signed [7:0] vbat_code = 8'sd0;
  logic lb_tip, lb_ring, rr, ra, stat_n;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ring_switch_ctrl #(.GAP_CYC(GAP_T), .TO_CYC(TO_T)) u_ring_switch_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .hold_i(hold), .sd_ext_n_i(sd_ext_n),
    .temp_valid_i(temp_valid), .temp_code_i(temp_code),
    .vbat_valid_i(vbat_valid), .vbat_code_i(vbat_code), .zc_i(zc),
    .lb_tip_en_o(lb_tip), .lb_ring_en_o(lb_ring), .rr_en_o(rr), .ra_en_o(ra),
    .sd_stat_n_o(stat_n)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_sw(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {lb_tip, lb_ring, rr, ra};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: switches act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic chk_stat(input string tag, input logic exp);
    n_run++;
    if (stat_n !== exp) begin
      n_fail++;
      $display("FAIL %s: status act=%b exp=%b", tag, stat_n, exp);
    end
  endtask

  task automatic go_ring();
    mode = 1'b1;
    step(GAP_T + 1);
  endtask

  task automatic t_reset();
    step(2);
    chk_sw("R11 in reset", V_OFF);
    chk_stat("R11 in reset", 1'b0);
    rst_n = 1'b1;
    step(5);
    chk_sw("R11 no samples yet", V_OFF);
    temp_code = 8'd25; temp_valid = 1'b1;
    step(2);
    chk_stat("R11 thermal cleared", 1'b1);
    chk_sw("R11 battery still in fault", V_OFF);
    vbat_code = -8'sd48; vbat_valid = 1'b1;
    step(2);
    chk_sw("R1 idle after bring-up", V_IDLE);
  endtask

  task automatic t_ring_entry();
    mode = 1'b1;
    step(1);
    chk_sw("R9 gap cycle 1", V_OFF);
    step(1);
    chk_sw("R9 gap cycle 2", V_OFF);
    step(1);
    chk_sw("R2 ringing", V_RING);
  endtask

  task automatic t_drain_zc();
    mode = 1'b0;
    step(1);
    chk_sw("R8 drain entry", V_DRAIN);
    step(10);
    chk_sw("R8 drain waits", V_DRAIN);
    zc = 1'b1;
    step(1);
    zc = 1'b0;
    chk_sw("R8 released at zero crossing", V_IDLE);
  endtask

  task automatic t_timeout();
    go_ring();
    chk_sw("R10 ringing before timeout", V_RING);
    mode = 1'b0;
    step(1);
    step(TO_T - 1);
    chk_sw("R10 last cycle of window", V_DRAIN);
    step(1);
    chk_sw("R10 forced off", V_IDLE);
  endtask

  task automatic t_hold();
    hold = 1'b1;
    step(1);
    mode = 1'b1;
    step(5);
    chk_sw("R3 idle held", V_IDLE);
    hold = 1'b0;
    step(1);
    chk_sw("R4 follows live mode", V_OFF);
    step(2);
    chk_sw("R4 reaches ringing", V_RING);
    hold = 1'b1;
    step(1);
    mode = 1'b0;
    step(5);
    chk_sw("R3 ringing held", V_RING);
    hold = 1'b0;
    step(1);
    chk_sw("R4 release to drain", V_DRAIN);
    zc = 1'b1;
    step(1);
    zc = 1'b0;
    chk_sw("R4 back to idle", V_IDLE);
  endtask

  task automatic t_ext_sd();
    hold = 1'b1;
    sd_ext_n = 1'b0;
    step(1);
    chk_sw("R5 sync delay", V_IDLE);
    step(1);
    chk_sw("R5 forced off", V_OFF);
    chk_stat("R5 status unaffected", 1'b1);
    sd_ext_n = 1'b1;
    hold = 1'b0;
    step(2);
    chk_sw("R5 still off at release", V_OFF);
    step(1);
    chk_sw("R5 resumes idle", V_IDLE);
    go_ring();
    mode = 1'b0;
    step(1);
    chk_sw("R5 drain before shutdown", V_DRAIN);
    sd_ext_n = 1'b0;
    step(2);
    chk_sw("R5 access dropped by shutdown", V_OFF);
    sd_ext_n = 1'b1;
    step(3);
    chk_sw("R5 idle after drain shutdown", V_IDLE);
  endtask

  task automatic t_therm();
    temp_code = 8'd150;
    step(2);
    chk_sw("R6 150 does not trip", V_IDLE);
    chk_stat("R6 150 status", 1'b1);
    temp_code = 8'd151;
    step(1);
    chk_sw("R6 151 trips", V_OFF);
    chk_stat("R6 status low", 1'b0);
    temp_code = 8'd139;
    step(3);
    chk_sw("R6 139 keeps fault", V_OFF);
    chk_stat("R6 139 status", 1'b0);
    temp_code = 8'd138;
    step(1);
    chk_stat("R6 138 clears", 1'b1);
    step(1);
    chk_sw("R6 idle after clear", V_IDLE);
  endtask

  task automatic t_vbat();
    vbat_code = -8'sd10;
    step(2);
    chk_sw("R7 -10 does not trip", V_IDLE);
    vbat_code = -8'sd9;
    step(1);
    chk_sw("R7 -9 trips", V_OFF);
    chk_stat("R7 status stays high", 1'b1);
    vbat_code = -8'sd15;
    step(3);
    chk_sw("R7 -15 keeps fault", V_OFF);
    vbat_code = -8'sd16;
    step(2);
    chk_sw("R7 idle after clear", V_IDLE);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_ring_entry();
    t_drain_zc();
    t_timeout();
    t_hold();
    t_ext_sd();
    t_therm();
    t_vbat();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: act=expired exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule